// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is a single bank of general-purpose I/O pins sitting behind a simple 32-bit register bus. Software sets pin output levels, chooses per-pin direction and enables the pad drivers. It reads the pin levels back through a two-stage synchronizer. The bank width is a parameter of up to 32 pins. Register bits above that width do not exist.

Two half-word write ports let software change any subset of 16 pins in one bus write, without a read-modify-write cycle. The upper half of the written word is an inverted write mask and the lower half is the new data. A full-word data register reaches the same output storage. Reads are registered and return data one cycle after the read strobe.

Top module: `masked_gpio_bank`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pin_out, pin_oe and bus_rdata are all zero, and the output, direction and enable registers hold zero.
- R2: A write to offset 0x000 updates output pin i (i = 0..15) from data bit i only when mask bit 16+i is 0. Pins whose mask bit is 1 keep their value.
- R3: A write to offset 0x004 updates output pin 16+k (k = 0..15) from data bit k only when mask bit 16+k is 0. Pins whose mask bit is 1 keep their value.
- R4: A write to offset 0x040 replaces every output bit. A read of 0x040 returns the output data. pin_out changes only on a write.
- R5: Offset 0x060 is read-only and returns pin_in as delayed by a two-flop synchronizer. A read issued in the cycle that pin_in changes, and a read issued in the next cycle, both return the old level. Writes to 0x060 change nothing.
- R6: Offset 0x204 is the direction register. It is readable and writable, a 1 bit marks an output, and it resets to 0.
- R7: Offset 0x208 is the output-enable register and is readable and writable. pin_oe[i] is 1 exactly when direction bit i and enable bit i are both 1.
- R8: Register bits at or above NPINS read as 0, and writes to them are ignored.
- R9: A read of 0x000 returns output pins 15..0 in bits 15..0, and a read of 0x004 returns output pins 31..16 in bits 15..0. In both cases bits 31..16 read 0. Any unmapped offset reads 0.
- R10: bus_rdata carries the addressed value in the cycle after bus_rd, and is 0 after a cycle without bus_rd. A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output level per pin |
| pin_oe | output | NPINS | Pad driver enable per pin |

## Verification
A read and a write can hit the same register in one cycle. The bench raises both strobes together on the full data register and expects the read to return the value from before the write. A follow-up read must then show the new value. Pin sampling also overlaps with reads of the input register: the bench changes pin_in in the same cycle as a run of back-to-back reads and expects the old level twice before the new level appears, which pins down the synchronizer depth exactly.

// File: rtl/masked_gpio_bank.sv
module masked_gpio_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_rd,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);

  localparam logic [AW-1:0] OFS_MW_LO = AW'('h000);
  localparam logic [AW-1:0] OFS_MW_HI = AW'('h004);
  localparam logic [AW-1:0] OFS_DATA  = AW'('h040);
  localparam logic [AW-1:0] OFS_IN    = AW'('h060);
  localparam logic [AW-1:0] OFS_DIR   = AW'('h204);
  localparam logic [AW-1:0] OFS_OE    = AW'('h208);

  logic [NPINS-1:0] out_q, dir_q, oe_q, sync1_q, sync2_q;
  logic [31:0]      out32, out_next, rd_mux;
  logic [15:0]      upd;

  assign out32 = 32'(out_q);
  assign upd   = ~bus_wdata[31:16];

  always_comb begin
    out_next = out32;
    if (bus_wr) begin
      case (bus_addr)
        OFS_MW_LO: out_next[15:0]  = (out32[15:0]  & ~upd) | (bus_wdata[15:0] & upd);
        OFS_MW_HI: out_next[31:16] = (out32[31:16] & ~upd) | (bus_wdata[15:0] & upd);
        OFS_DATA:  out_next        = bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MW_LO: rd_mux = {16'h0, out32[15:0]};
      OFS_MW_HI: rd_mux = {16'h0, out32[31:16]};
      OFS_DATA:  rd_mux = out32;
      OFS_IN:    rd_mux = 32'(sync2_q);
      OFS_DIR:   rd_mux = 32'(dir_q);
      OFS_OE:    rd_mux = 32'(oe_q);
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      dir_q     <= '0;
      oe_q      <= '0;
      sync1_q   <= '0;
      sync2_q   <= '0;
      bus_rdata <= '0;
    end else begin
      out_q     <= out_next[NPINS-1:0];
      sync1_q   <= pin_in;
      sync2_q   <= sync1_q;
      bus_rdata <= bus_rd ? rd_mux : 32'h0;
      if (bus_wr && bus_addr == OFS_DIR) dir_q <= bus_wdata[NPINS-1:0];
      if (bus_wr && bus_addr == OFS_OE)  oe_q  <= bus_wdata[NPINS-1:0];
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q & oe_q;

endmodule

// File: rtl/masked_gpio_bank_chk.sv
module masked_gpio_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe
);

  logic mapped, cfg_wr;
  assign mapped = bus_addr inside {AW'('h000), AW'('h004), AW'('h040),
                                   AW'('h060), AW'('h204), AW'('h208)};
  assign cfg_wr = bus_wr && (bus_addr == AW'('h204) || bus_addr == AW'('h208));

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'h0); // R10
  AST_OUT_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out)); // R4
  AST_OE_HOLD_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(pin_oe)); // R7
  AST_LO_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h000) && bus_wdata[31:16] == 16'hFFFF) |=> $stable(pin_out)); // R2
  AST_HI_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h004) && bus_wdata[31:16] == 16'hFFFF) |=> $stable(pin_out)); // R3
  AST_INPUT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h060)) |=> ($stable(pin_out) && $stable(pin_oe))); // R5
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> bus_rdata == 32'h0); // R9
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_rdata >> NPINS) == 32'h0); // R8

endmodule

bind masked_gpio_bank masked_gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/masked_gpio_bank_test.sv
`timescale 1ns/1ps
module masked_gpio_bank_test;
  localparam int NP = 22;
  localparam logic [31:0] IMPL = (32'h1 << NP) - 1;

  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  masked_gpio_bank #(.NPINS(NP), .AW(12)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); v = bus_rdata; bus_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] exp, v, v1, v2, v3, d, dirv, oev, oldv;
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", 32'(pin_out), 0);
    check("R1 pin_oe in reset", 32'(pin_oe), 0);
    check("R1 rdata in reset", bus_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 pin_out after reset", 32'(pin_out), 0);
    rd(12'h204, v); check("R1 direction reset", v, 0);
    rd(12'h208, v); check("R1 enable reset", v, 0);

    exp = 0;
    for (int i = 0; i < 16; i++) begin
      d = {~(32'h1 << i)} << 16 | {16'h0, ~exp[15:0]};
      wr(12'h000, d);
      exp[i] = ~exp[i];
      check($sformatf("R2 single pin %0d", i), 32'(pin_out), exp);
    end
    for (int k = 0; k < 16; k++) begin
      d = (~(32'h1 << k)) << 16 | {16'h0, ~exp[31:16]};
      wr(12'h004, d);
      if (16 + k < NP) exp[16+k] = ~exp[16+k];
      check($sformatf("R3 single pin %0d", 16 + k), 32'(pin_out), exp);
      rd(12'h004, v); check($sformatf("R9 high readback k=%0d", k), v, {16'h0, exp[31:16]});
    end
    rd(12'h000, v); check("R9 low readback", v, {16'h0, exp[15:0]});

    wr(12'h000, 32'hFFFF_5A5A);
    check("R2 all masked", 32'(pin_out), exp);
    wr(12'h004, 32'hFFFF_A5A5);
    check("R3 all masked", 32'(pin_out), exp);
    d = 32'h0F0F_1234;
    wr(12'h000, d);
    exp[15:0] = (exp[15:0] & 16'h0F0F) | (16'h1234 & 16'hF0F0);
    check("R2 multi-bit mask", 32'(pin_out), exp);
    d = 32'h00F0_00FF;
    wr(12'h004, d);
    exp[31:16] = ((exp[31:16] & 16'h00F0) | (16'h00FF & 16'hFF0F));
    exp &= IMPL;
    check("R3 multi-bit mask", 32'(pin_out), exp);

    wr(12'h040, 32'hDEAD_BEEF);
    exp = 32'hDEAD_BEEF & IMPL;
    check("R4 full write", 32'(pin_out), exp);
    rd(12'h040, v); check("R8 full readback upper zero", v, exp);

    @(negedge clk); bus_addr = 12'h040; bus_wdata = 32'h0012_3456; bus_wr = 1; bus_rd = 1;
    @(negedge clk); v = bus_rdata; bus_wr = 0; bus_rd = 0;
    check("R10 read during write returns old", v, exp);
    exp = 32'h0012_3456 & IMPL;
    @(negedge clk); check("R10 idle rdata zero", bus_rdata, 0);
    rd(12'h040, v); check("R10 readback after write", v, exp);

    pin_in = 22'h2A_5C3D;
    repeat (3) @(negedge clk);
    rd(12'h060, v); check("R5 input read", v, 32'h2A_5C3D);
    @(negedge clk); pin_in = 22'h15_A3C2; bus_addr = 12'h060; bus_rd = 1;
    @(negedge clk); v1 = bus_rdata;
    @(negedge clk); v2 = bus_rdata;
    @(negedge clk); v3 = bus_rdata; bus_rd = 0;
    check("R5 sync first read old", v1, 32'h2A_5C3D);
    check("R5 sync second read old", v2, 32'h2A_5C3D);
    check("R5 sync third read new", v3, 32'h15_A3C2);
    wr(12'h060, 32'hFFFF_FFFF);
    check("R5 write to input ignored", 32'(pin_out), exp);
    rd(12'h060, v); check("R5 input after write", v, 32'h15_A3C2);

    for (int j = 0; j < 8; j++) begin
      dirv = (32'hA5A5_5A5A << j) | (32'hA5A5_5A5A >> (32 - j));
      oev  = (32'h3C3C_F00F << (2 * j)) | (32'h3C3C_F00F >> (32 - 2 * j));
      if (j == 0) oev = 32'h3C3C_F00F;
      wr(12'h204, dirv);
      wr(12'h208, oev);
      check($sformatf("R7 oe gating j=%0d", j), 32'(pin_oe), dirv & oev & IMPL);
      rd(12'h204, v); check($sformatf("R6 direction readback j=%0d", j), v, dirv & IMPL);
      rd(12'h208, v); check($sformatf("R8 enable readback j=%0d", j), v, oev & IMPL);
    end
    wr(12'h204, 32'h0); wr(12'h208, 32'hFFFF_FFFF);
    check("R7 enable without direction", 32'(pin_oe), 0);
    wr(12'h204, 32'hFFFF_FFFF);
    check("R6 all outputs", 32'(pin_oe), IMPL);

    oldv = exp;
    foreach (v1[b]) begin end
    rd(12'h008, v); check("R9 unmapped 0x008", v, 0);
    rd(12'h044, v); check("R9 unmapped 0x044", v, 0);
    rd(12'h200, v); check("R9 unmapped 0x200", v, 0);
    rd(12'h20C, v); check("R9 unmapped 0x20C", v, 0);
    wr(12'h20C, 32'hFFFF_FFFF);
    check("R9 unmapped write ignored", 32'(pin_out), oldv);

    rst_n = 0;
    @(negedge clk);
    check("R1 reset clears outputs", 32'(pin_out), 0);
    check("R1 reset clears enables", 32'(pin_oe), 0);
    rst_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule